// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port on a simple register bus. Its data register sits behind a 1 KB alias window: the word address inside that window is itself a per-pin mask. A write can therefore set or clear any subset of output pins in one cycle, and a read can return only the pins of interest, with no read-modify-write sequence in software.

Each pin is either an input or an output, set by a direction register. Input pins reach the data register through a two-stage synchronizer. Output pins show the stored data value. Pins set as inputs drive a logic 1 on the output vector, so an undriven line floats high. Eight pad-control registers (drive strength, open drain, pulls, slew, digital enable) are stored and read back but drive nothing. A block of twelve identification bytes sits at the top of the 4 KB map. Interrupt generation belongs to a separate block.

The block works on single-cycle bus accesses with no handshake. The offset is decoded into one address region at a time, and the read data is registered, so it appears one clock after the offset is presented.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset the data and direction registers are 0 and pin_out is 0xFF. The pad register at 0x404 (2 mA drive) reads 0xFF and the other seven pad registers read 0.
- R2: A read at any offset below 0x400 returns the data register ANDed with mask = offset[9:2]. Bits outside the mask read as 0.
- R3: A write at any offset below 0x400 changes only the data bits that are set in both offset[9:2] and the direction register. All other bits keep their value.
- R4: On a pin whose direction bit is 0 (input), the data bit follows pin_in through a two-flop synchronizer. It takes the new pin level on the third rising clock edge after the change.
- R5: On a pin whose direction bit is 1 (output), changes on pin_in have no effect on the data bit.
- R6: pin_out equals the data bit on output pins and 1 on input pins.
- R7: The direction register is at offset 0x400 and reads back what was written. A 1 bit marks an output.
- R8: The pad registers sit at offsets 0x404 + 4*k for k = 0..7, in this order: drive 2 mA, drive 4 mA, drive 8 mA, open drain, pull-up, pull-down, slew control, digital enable. Each one reads back what was written.
- R9: Offsets 0xFD0 to 0xFFC return one identification byte per word, in this order: 00,00,00,00,61,10,04,00,0D,F0,05,B1. Writes there are ignored.
- R10: Offsets 0x424 through 0xFCC read as 0, and writes to them change no register.
- R11: bus_rd_data is registered. It shows the value for the offset that was present at the previous rising edge. Offset bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_offset | input | 12 | Byte offset of the access |
| bus_wr_en | input | 1 | Write strobe for the current offset |
| bus_wr_data | input | 8 | Write data |
| bus_rd_data | output | 8 | Registered read data |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Driven pin levels |

## Verification
A corrupted data or direction bit shows up on pin_out in the cycle after the faulty edge. This can be a wrong write mask, or an input pin that stops following its synchronizer. A masked read shows the same fault one cycle later. A bad address decode shows up on the next read of the affected offset: a reserved word that returns data, or a pad or direction register that a stray write has overwritten. The bench compares every read and pin_out sample with a model of the register state. Each pin change is given the full synchronizer delay before the data register is compared.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    localparam int PAD_COUNT = 8;
    localparam int ID_COUNT  = 12;

    typedef enum logic [2:0] {
        RGN_DATA,
        RGN_DIR,
        RGN_PAD,
        RGN_ID,
        RGN_RSVD
    } region_e;

    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        logic [7:0] b;
        unique case (idx)
            4'd4:    b = 8'h61;
            4'd5:    b = 8'h10;
            4'd6:    b = 8'h04;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_mask_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int W      = 8
) (
    input  logic [ADDR_W-1:0] offset,
    output region_e           region,
    output logic [W-1:0]      mask,
    output logic [3:0]        sub_idx
);
    localparam int DATA_LIMIT = 4 << W;
    localparam int DIR_OFF    = DATA_LIMIT;
    localparam int PAD_FIRST  = DIR_OFF + 4;
    localparam int PAD_LAST   = DIR_OFF + 4 * PAD_COUNT;
    localparam int ID_BASE    = (1 << ADDR_W) - 4 * ID_COUNT;

    int off_i;

    always_comb begin
        off_i   = int'(offset);
        mask    = offset[W+1:2];
        sub_idx = 4'd0;
        if (off_i < DATA_LIMIT) begin
            region = RGN_DATA;
        end else if (off_i >> 2 == DIR_OFF >> 2) begin
            region = RGN_DIR;
        end else if (off_i >= PAD_FIRST && off_i <= PAD_LAST + 3) begin
            region  = RGN_PAD;
            sub_idx = 4'((off_i - PAD_FIRST) >> 2);
        end else if (off_i >= ID_BASE) begin
            region  = RGN_ID;
            sub_idx = 4'((off_i - ID_BASE) >> 2);
        end else begin
            region = RGN_RSVD;
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_async,
    output logic [W-1:0] pin_sync
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= pin_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign pin_sync = stg[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_mask_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  region_e                       region,
    input  logic [W-1:0]                  mask,
    input  logic [3:0]                    sub_idx,
    input  logic [W-1:0]                  wr_data,
    input  logic [W-1:0]                  pin_sync,
    output logic [W-1:0]                  data_q,
    output logic [W-1:0]                  dir_q,
    output logic [PAD_COUNT-1:0][W-1:0]   pad_q
);
    logic [W-1:0] wmask;
    logic [W-1:0] data_d;

    always_comb begin
        wmask  = (wr_en && region == RGN_DATA) ? (mask & dir_q) : '0;
        data_d = (data_q & dir_q) | (pin_sync & ~dir_q);
        data_d = (data_d & ~wmask) | (wr_data & wmask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          dir_q <= '0;
        else if (wr_en && region == RGN_DIR) dir_q <= wr_data;
    end

    for (genvar g = 0; g < PAD_COUNT; g++) begin : g_pad
        localparam logic [W-1:0] RST_VAL = (g == 0) ? '1 : '0;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pad_q[g] <= RST_VAL;
            else if (wr_en && region == RGN_PAD && sub_idx == 4'(g))
                pad_q[g] <= wr_data;
        end
    end

endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
    import gpio_mask_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_offset,
    input  logic              bus_wr_en,
    input  logic [W-1:0]      bus_wr_data,
    output logic [W-1:0]      bus_rd_data,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out
);
    region_e                     region;
    logic [W-1:0]                mask;
    logic [3:0]                  sub_idx;
    logic [W-1:0]                sync_q;
    logic [W-1:0]                data_q;
    logic [W-1:0]                dir_q;
    logic [PAD_COUNT-1:0][W-1:0] pad_q;
    logic [W-1:0]                pad_rd;
    logic [W-1:0]                rd_d;

    gpio_addr_decode #(.ADDR_W(ADDR_W), .W(W)) u_dec (
        .offset  (bus_offset),
        .region  (region),
        .mask    (mask),
        .sub_idx (sub_idx)
    );

    gpio_in_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .pin_sync  (sync_q)
    );

    gpio_port_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr_en),
        .region   (region),
        .mask     (mask),
        .sub_idx  (sub_idx),
        .wr_data  (bus_wr_data),
        .pin_sync (sync_q),
        .data_q   (data_q),
        .dir_q    (dir_q),
        .pad_q    (pad_q)
    );

    always_comb begin
        pad_rd = '0;
        for (int i = 0; i < PAD_COUNT; i++) begin
            if (sub_idx == 4'(i)) pad_rd = pad_q[i];
        end
    end

    always_comb begin
        rd_d = '0;
        unique case (region)
            RGN_DATA: rd_d = data_q & mask;
            RGN_DIR:  rd_d = dir_q;
            RGN_PAD:  rd_d = pad_rd;
            RGN_ID:   rd_d = W'(id_byte(sub_idx));
            RGN_RSVD: rd_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rd_data <= '0;
        else        bus_rd_data <= rd_d;
    end

    assign pin_out = (data_q & dir_q) | ~dir_q;

endmodule

// File: rtl/gpio_masked_port_chk.sv
module gpio_masked_port_chk #(
    parameter int ADDR_W = 12,
    parameter int W      = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_offset,
    input logic              bus_wr_en,
    input logic [W-1:0]      bus_wr_data,
    input logic [W-1:0]      bus_rd_data,
    input logic [W-1:0]      pin_out,
    input logic [W-1:0]      data_q,
    input logic [W-1:0]      dir_q,
    input logic [W-1:0]      sync_q
);
    localparam int WIN = 4 << W;

    logic         in_win;
    logic         rsvd_hit;
    logic         dir_hit;
    logic [W-1:0] amask;
    logic [W-1:0] wmask;

    assign in_win   = int'(bus_offset) < WIN;
    assign rsvd_hit = int'(bus_offset) >= 'h424 && int'(bus_offset) <= 'hFCF;
    assign dir_hit  = (int'(bus_offset) >> 2) == (WIN >> 2);
    assign amask    = bus_offset[W+1:2];
    assign wmask    = (bus_wr_en && in_win) ? amask : '0;

    // R3 and R5: output bits change only when a masked window write hits them
    a_r3_out_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_q ^ $past(data_q)) & $past(dir_q) & ~$past(wmask)) == '0);

    // R4: input bits take the synchronizer output
    a_r4_input_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_q ^ $past(sync_q)) & ~$past(dir_q)) == '0);

    // R6: input pins float high
    a_r6_inputs_high: assert property (@(posedge clk) disable iff (!rst_n)
        &(pin_out | dir_q));

    // R7: direction load
    a_r7_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr_en && dir_hit) |-> dir_q == $past(bus_wr_data));

    // R2: unmasked bits read as zero
    a_r2_unmasked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_win) |-> (bus_rd_data & ~$past(amask)) == '0);

    // R10: reserved range reads zero
    a_r10_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rsvd_hit) |-> bus_rd_data == '0);

endmodule

bind gpio_masked_port gpio_masked_port_chk #(.ADDR_W(ADDR_W), .W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_offset  (bus_offset),
    .bus_wr_en   (bus_wr_en),
    .bus_wr_data (bus_wr_data),
    .bus_rd_data (bus_rd_data),
    .pin_out     (pin_out),
    .data_q      (data_q),
    .dir_q       (dir_q),
    .sync_q      (sync_q)
);

// File: tb/gpio_masked_port_tb.sv
`timescale 1ns/1ps
module gpio_masked_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_offset = '0;
    logic        bus_wr_en = 1'b0;
    logic [7:0]  bus_wr_data = '0;
    logic [7:0]  bus_rd_data;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] m_data = '0;
    logic [7:0] m_dir  = '0;
    logic [7:0] m_pad [8];

    always #2.5 clk = ~clk;

    gpio_masked_port u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_offset  (bus_offset),
        .bus_wr_en   (bus_wr_en),
        .bus_wr_data (bus_wr_data),
        .bus_rd_data (bus_rd_data),
        .pin_in      (pin_in),
        .pin_out     (pin_out)
    );

    function automatic logic [7:0] exp_id(input int k);
        logic [7:0] t [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h10,
                               8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        return t[k];
    endfunction

    function automatic logic [7:0] exp_out();
        return (m_data & m_dir) | ~m_dir;
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] off, input logic [7:0] val);
        @(negedge clk);
        bus_offset  = off;
        bus_wr_data = val;
        bus_wr_en   = 1'b1;
        @(negedge clk);
        bus_wr_en   = 1'b0;
        if (off < 12'h400) begin
            logic [7:0] wm = off[9:2] & m_dir;
            m_data = (m_data & ~wm) | (val & wm);
        end else if (off[11:2] == 10'h100) begin
            m_dir  = val;
            m_data = (m_data & m_dir) | (pin_in & ~m_dir);
        end else if (off >= 12'h404 && off <= 12'h423) begin
            m_pad[(off - 12'h404) >> 2] = val;
        end
    endtask

    task automatic bus_read(input logic [11:0] off, output logic [7:0] v);
        @(negedge clk);
        bus_offset = off;
        bus_wr_en  = 1'b0;
        @(posedge clk);
        #1 v = bus_rd_data;
    endtask

    task automatic set_pins(input logic [7:0] p);
        @(negedge clk);
        pin_in = p;
        repeat (4) @(negedge clk);
        m_data = (m_data & m_dir) | (p & ~m_dir);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 8; k++) m_pad[k] = (k == 0) ? 8'hFF : 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1 check("R1 pin_out", pin_out, 8'hFF);
        bus_read(12'h400, v); check("R1 dir", v, 8'h00);
        bus_read(12'h3FC, v); check("R1 data", v, 8'h00);
        for (int k = 0; k < 8; k++) begin
            bus_read(12'(12'h404 + 4 * k), v); check("R1 pad", v, m_pad[k]);
        end

        // R7 direction, R3 masked write, R6 outputs
        bus_write(12'h400, 8'h0F); bus_read(12'h400, v); check("R7 dir rd", v, 8'h0F);
        bus_write(12'h3FC, 8'hFF);
        #1 check("R6 pin_out", pin_out, exp_out());
        bus_write(12'h400, 8'hFF);
        bus_write(12'h028, 8'h00);  // mask 0x0A
        bus_read(12'h3FC, v); check("R3 partial write", v, m_data);
        check("R3 exact", v, 8'hF5 & m_data);

        // R2 masked read; offset bits [1:0] ignored (R11)
        bus_read(12'h0F3, v); check("R2 masked read", v, m_data & 8'h3C);
        bus_read(12'h000, v); check("R2 zero mask", v, 8'h00);

        // R5 inputs ignored on outputs
        set_pins(8'h5A);
        bus_read(12'h3FC, v); check("R5 outputs hold", v, m_data);

        // R4 inputs follow pins
        bus_write(12'h400, 8'h00);
        set_pins(8'hC3);
        bus_read(12'h3FC, v); check("R4 input follow", v, 8'hC3);
        #1 check("R6 all inputs high", pin_out, 8'hFF);

        // R8 pad registers
        for (int k = 0; k < 8; k++) bus_write(12'(12'h404 + 4 * k), 8'(8'h11 * (k + 1)));
        for (int k = 0; k < 8; k++) begin
            bus_read(12'(12'h404 + 4 * k), v); check("R8 pad rw", v, m_pad[k]);
        end

        // R9 identification bytes, writes ignored
        bus_write(12'hFE0, 8'h77);
        for (int k = 0; k < 12; k++) begin
            bus_read(12'(12'hFD0 + 4 * k), v); check("R9 id", v, exp_id(k));
        end

        // R10 reserved range
        bus_write(12'h424, 8'hFF);
        bus_write(12'hFCC, 8'hFF);
        bus_write(12'h800, 8'hFF);
        bus_read(12'h424, v); check("R10 rsvd low", v, 8'h00);
        bus_read(12'hFCC, v); check("R10 rsvd high", v, 8'h00);
        bus_read(12'h400, v); check("R10 dir untouched", v, m_dir);
        bus_read(12'h420, v); check("R10 pad untouched", v, m_pad[7]);
        bus_read(12'h3FC, v); check("R10 data untouched", v, m_data);

        // Random mix covering R2 R3 R4 R5 R6
        for (int it = 0; it < 300; it++) begin
            int op = int'($urandom_range(0, 3));
            logic [11:0] off = 12'($urandom_range(0, 12'h3FF));
            logic [7:0]  val = 8'($urandom);
            case (op)
                0: bus_write(off, val);
                1: bus_write(12'h400, val);
                2: set_pins(val);
                default: begin
                    bus_read(off, v);
                    check("R2 random read", v, m_data & off[9:2]);
                end
            endcase
            #1 check("R6 random pin_out", pin_out, exp_out());
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule